// File: doc/BRIEF.md
# Fully-Associative Cache Lookup with Cold/Capacity Miss Labels

This block is the lookup and replacement core of a small fully-associative cache. Each 16-bit request address is split into a block number (the address with its 6 offset bits removed) and a byte offset. The block number is compared in parallel against the stored tag of every line, because a block may live in any line. A hit returns the whole 64-byte block and the line number one cycle after the request is taken.

On a miss the block asks a memory-side port for the block and waits. When memory hands the block back, the block is written into a line and the response goes out. Free lines are filled first. Once every line is in use, the line that has gone longest without being touched is the one replaced. Every miss is labelled. A miss on a block never touched since reset is a cold miss. A miss on a block that was touched before, and has since been pushed out, is a capacity miss. A 1024-bit record of touched block numbers tells the two apart.

Top module: `fa_cache`

## Requirements
- R1: The stored tag is req_addr[15:6]. Any two addresses with the same bits [15:6] (the same 64-byte block, from low six bits all clear through all set) hit the same line once that block is resident, and at most one line ever matches a tag.
- R2: A request taken (req_valid and req_ready high at a clock edge) that hits gives, on the next cycle, resp_valid=1, resp_kind=2'b00, resp_slot equal to the holding line and resp_data equal to that line's block. No memory request is raised.
- R3: A request taken that misses gives, on the next cycle, mem_req_valid=1 with mem_req_blk=req_addr[15:6] and no response. The clock edge where mem_fill_valid is high while mem_req_valid is high installs mem_fill_data. On the next cycle resp_valid=1, resp_data equals the fill data, and mem_req_valid is 0.
- R4: While any line is invalid, a miss fills the lowest-numbered invalid line.
- R5: When all lines are valid, a miss replaces the least recently used line. Both hits and fills count as uses.
- R6: A miss on a block number not requested since reset reports resp_kind=2'b01 (cold).
- R7: A miss on a block number requested before since reset reports resp_kind=2'b10 (capacity).
- R8: While a fill is outstanding, req_ready is 0 and req_valid is ignored. It produces no response and no extra memory request.
- R9: A synchronous active-high reset empties every line and clears the ages and the record of touched blocks. After reset, req_ready=1, resp_valid=0 and mem_req_valid=0, and a later miss on any block is cold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 16 | Byte address of the request |
| req_ready | output | 1 | High when a request can be taken (no fill outstanding) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | 00 hit, 01 cold miss, 10 capacity miss |
| resp_slot | output | 3 | Line that holds the block |
| resp_data | output | 512 | The 64-byte block |
| mem_req_valid | output | 1 | Block fetch outstanding |
| mem_req_blk | output | 10 | Block number to fetch |
| mem_fill_valid | input | 1 | Memory returns the requested block |
| mem_fill_data | input | 512 | Returned block contents |

## Verification
The first directed pattern reads different offsets inside one block and the first byte of the next block. This separates correct tag extraction from an off-by-one offset width. A second pattern fills all eight lines, re-touches the oldest line and then misses. This shows whether hits refresh the replacement order or only fills do, and re-requesting the evicted block tells a capacity label from a cold one. Random traffic over a pool of twelve blocks, larger than the line count, with random offsets and fill delays, mixes hits, cold misses and capacity misses in changing orders. Requests sent during a pending fill, and a reset in mid-run, show whether busy-time input and the touched-block record are handled correctly.

// File: rtl/fac_pkg.sv
package fac_pkg;
  typedef enum logic [1:0] {
    KIND_HIT  = 2'b00,
    KIND_COLD = 2'b01,
    KIND_CAP  = 2'b10
  } kind_e;
endpackage

// File: rtl/fac_tag_match.sv
// Parallel compare of one tag against every stored line tag.
module fac_tag_match #(
  parameter int LINES = 8,
  parameter int TAG_W = 10,
  localparam int SLOT_W = $clog2(LINES)
) (
  input  logic [TAG_W-1:0]       tag_in,
  input  logic [LINES*TAG_W-1:0] tags_flat,
  input  logic [LINES-1:0]       line_valid,
  output logic [LINES-1:0]       match_vec,
  output logic                   hit,
  output logic [SLOT_W-1:0]      hit_slot
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_vec[g] = line_valid[g] && (tags_flat[g*TAG_W +: TAG_W] == tag_in);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < LINES; i++)
      if (match_vec[i]) hit_slot = SLOT_W'(i);
  end
endmodule

// File: rtl/fac_lru_ages.sv
// Per-line age counters; age 0 = most recent, LINES-1 = oldest.
module fac_lru_ages #(
  parameter int LINES = 8,
  localparam int SLOT_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch,
  input  logic [SLOT_W-1:0] touch_slot,
  input  logic [LINES-1:0]  line_valid,
  output logic [SLOT_W-1:0] victim
);
  logic [SLOT_W-1:0] age_q [LINES];
  logic [SLOT_W:0]   thr;

  // A line that was invalid is younger than nothing: every valid line ages.
  assign thr = line_valid[touch_slot] ? {1'b0, age_q[touch_slot]}
                                      : (SLOT_W+1)'(LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= '0;
    end else if (touch) begin
      for (int i = 0; i < LINES; i++) begin
        if (SLOT_W'(i) == touch_slot)
          age_q[i] <= '0;
        else if (line_valid[i] && ({1'b0, age_q[i]} < thr))
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && !line_valid[i]) begin
        victim = SLOT_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < LINES; i++)
        if (age_q[i] == SLOT_W'(LINES-1)) victim = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6,
  parameter int LINES  = 8,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int DATA_W = 8 << OFF_W,
  localparam int SLOT_W = $clog2(LINES),
  localparam int SEEN_N = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [1:0]        resp_kind,
  output logic [SLOT_W-1:0] resp_slot,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [TAG_W-1:0]  mem_req_blk,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data
);
  import fac_pkg::*;

  logic [TAG_W-1:0]       tag_q [LINES];
  logic [DATA_W-1:0]      data_q [LINES];
  logic [LINES*TAG_W-1:0] tags_flat;
  logic [LINES-1:0]       valid_q, match_vec;
  logic [SEEN_N-1:0]      seen_q;
  logic                   busy_q, seen_was_q, hit_any;
  logic [SLOT_W-1:0]      hit_slot, victim, pend_slot_q, touch_slot;
  logic [TAG_W-1:0]       req_tag;
  logic                   take, hit_fire, miss_fire, fill_fire;

  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign req_ready = !busy_q;
  assign take      = req_valid && !busy_q;
  assign hit_fire  = take && hit_any;
  assign miss_fire = take && !hit_any;
  assign fill_fire = busy_q && mem_fill_valid;
  assign touch_slot = fill_fire ? pend_slot_q : hit_slot;

  for (genvar g = 0; g < LINES; g++) begin : g_pack
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  fac_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .tag_in(req_tag), .tags_flat(tags_flat), .line_valid(valid_q),
    .match_vec(match_vec), .hit(hit_any), .hit_slot(hit_slot)
  );

  fac_lru_ages #(.LINES(LINES)) u_lru (
    .clk(clk), .rst(rst), .touch(hit_fire || fill_fire),
    .touch_slot(touch_slot), .line_valid(valid_q), .victim(victim)
  );

  // Line storage: no reset, single write port, suits RAM inference.
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[pend_slot_q]  <= mem_req_blk;
      data_q[pend_slot_q] <= mem_fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (hit_fire)       resp_data <= data_q[hit_slot];
    else if (fill_fire) resp_data <= mem_fill_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q       <= '0;
      seen_q        <= '0;
      busy_q        <= 1'b0;
      seen_was_q    <= 1'b0;
      pend_slot_q   <= '0;
      resp_valid    <= 1'b0;
      resp_kind     <= KIND_HIT;
      resp_slot     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_blk   <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (hit_fire) begin
        resp_valid <= 1'b1;
        resp_kind  <= KIND_HIT;
        resp_slot  <= hit_slot;
      end
      if (miss_fire) begin
        busy_q          <= 1'b1;
        mem_req_valid   <= 1'b1;
        mem_req_blk     <= req_tag;
        pend_slot_q     <= victim;
        seen_was_q      <= seen_q[req_tag];
        seen_q[req_tag] <= 1'b1;
      end
      if (fill_fire) begin
        busy_q               <= 1'b0;
        mem_req_valid        <= 1'b0;
        valid_q[pend_slot_q] <= 1'b1;
        resp_valid           <= 1'b1;
        resp_kind            <= seen_was_q ? KIND_CAP : KIND_COLD;
        resp_slot            <= pend_slot_q;
      end
    end
  end
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
  parameter int LINES = 8,
  localparam int SLOT_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              hit_any,
  input logic [LINES-1:0]  match_vec,
  input logic [LINES-1:0]  valid_q,
  input logic [SLOT_W-1:0] victim,
  input logic              resp_valid,
  input logic [1:0]        resp_kind,
  input logic              mem_req_valid,
  input logic              mem_fill_valid
);
  p_match_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  p_hit_resp_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && hit_any |=> resp_valid && resp_kind == 2'b00 && !mem_req_valid);

  p_miss_req_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !hit_any |=> mem_req_valid && !req_ready && !resp_valid);

  p_fill_done_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_fill_valid |=> !mem_req_valid && resp_valid && resp_kind != 2'b00);

  p_victim_free_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !hit_any && !(&valid_q) |-> !valid_q[victim]);

  p_busy_block_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
endmodule

bind fa_cache fa_cache_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .hit_any(hit_any), .match_vec(match_vec), .valid_q(valid_q), .victim(victim),
  .resp_valid(resp_valid), .resp_kind(resp_kind),
  .mem_req_valid(mem_req_valid), .mem_fill_valid(mem_fill_valid)
);

// File: tb/fa_cache_bench.sv
module fa_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES  = 8;
  localparam int DATA_W = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_ready, resp_valid, mem_req_valid;
  logic [1:0] resp_kind;
  logic [2:0] resp_slot;
  logic [DATA_W-1:0] resp_data;
  logic [9:0] mem_req_blk;
  logic mem_fill_valid = 1'b0;
  logic [DATA_W-1:0] mem_fill_data = '0;

  int n_checks = 0;
  int n_errors = 0;

  // Reference model state
  logic [9:0] m_tag [LINES];
  bit         m_val [LINES];
  int         m_age [LINES];
  bit         m_seen [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_cache u_fa_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_slot(resp_slot), .resp_data(resp_data), .mem_req_valid(mem_req_valid),
    .mem_req_blk(mem_req_blk), .mem_fill_valid(mem_fill_valid),
    .mem_fill_data(mem_fill_data)
  );

  function automatic logic [DATA_W-1:0] blk_pattern(input logic [9:0] t);
    logic [31:0] w;
    w = 32'(t) * 32'h9E37_79B1 + 32'h0000_1234;
    return {16{w}};
  endfunction

  function automatic int m_find(input logic [9:0] t);
    for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < LINES; i++) if (!m_val[i]) return i;
    for (int i = 0; i < LINES; i++) if (m_age[i] == LINES-1) return i;
    return 0;
  endfunction

  function automatic bit m_full();
    for (int i = 0; i < LINES; i++) if (!m_val[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic m_touch(input int s);
    int thr;
    thr = m_val[s] ? m_age[s] : LINES;
    for (int i = 0; i < LINES; i++) begin
      if (i == s) m_age[i] = 0;
      else if (m_val[i] && m_age[i] < thr) m_age[i] = m_age[i] + 1;
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_age[i] = 0; m_tag[i] = '0; end
    for (int i = 0; i < 1024; i++) m_seen[i] = 0;
  endtask

  task automatic chk(input bit ok, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; mem_fill_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_clear();
    chk(req_ready == 1'b1, "R9 req_ready after reset", DATA_W'(req_ready), 1);
    chk(resp_valid == 1'b0, "R9 resp_valid after reset", DATA_W'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R9 mem_req_valid after reset", DATA_W'(mem_req_valid), 0);
  endtask

  task automatic access(input logic [15:0] addr, input int lat, input bit poke);
    logic [9:0] t;
    int s, v;
    bit full;
    t = addr[15:6];
    s = m_find(t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (s >= 0) begin
      chk(resp_valid == 1'b1, "R2 hit resp_valid", DATA_W'(resp_valid), 1);
      chk(resp_kind == 2'b00, "R2 hit kind", DATA_W'(resp_kind), 0);
      chk(resp_slot == 3'(s), "R1 R2 hit slot", DATA_W'(resp_slot), DATA_W'(s));
      chk(resp_data == blk_pattern(t), "R2 hit data", resp_data, blk_pattern(t));
      chk(mem_req_valid == 1'b0, "R2 no mem request on hit", DATA_W'(mem_req_valid), 0);
      m_touch(s);
    end else begin
      v = m_victim();
      full = m_full();
      chk(mem_req_valid == 1'b1, "R3 mem_req_valid on miss", DATA_W'(mem_req_valid), 1);
      chk(mem_req_blk == t, "R3 mem_req_blk", DATA_W'(mem_req_blk), DATA_W'(t));
      chk(resp_valid == 1'b0, "R3 no response before fill", DATA_W'(resp_valid), 0);
      chk(req_ready == 1'b0, "R8 busy during fill", DATA_W'(req_ready), 0);
      for (int k = 0; k < lat; k++) begin
        if (poke) begin req_valid = 1'b1; req_addr = addr ^ 16'h4000; end
        @(negedge clk);
      end
      req_valid = 1'b0;
      if (poke) chk(resp_valid == 1'b0 && mem_req_valid == 1'b1, "R8 busy request ignored",
                    DATA_W'({resp_valid, mem_req_valid}), 1);
      mem_fill_valid = 1'b1; mem_fill_data = blk_pattern(t);
      @(negedge clk);
      mem_fill_valid = 1'b0;
      chk(resp_valid == 1'b1, "R3 fill response", DATA_W'(resp_valid), 1);
      if (m_seen[t])
        chk(resp_kind == 2'b10, "R7 capacity kind", DATA_W'(resp_kind), 2);
      else
        chk(resp_kind == 2'b01, "R6 cold kind", DATA_W'(resp_kind), 1);
      chk(resp_slot == 3'(v), full ? "R5 LRU victim slot" : "R4 lowest free slot",
          DATA_W'(resp_slot), DATA_W'(v));
      chk(resp_data == blk_pattern(t), "R3 fill data", resp_data, blk_pattern(t));
      chk(mem_req_valid == 1'b0, "R3 mem_req dropped", DATA_W'(mem_req_valid), 0);
      m_touch(v);
      m_val[v] = 1; m_tag[v] = t; m_seen[t] = 1;
      if (poke) begin
        @(negedge clk);
        chk(resp_valid == 1'b0 && mem_req_valid == 1'b0, "R8 no late effect",
            DATA_W'({resp_valid, mem_req_valid}), 0);
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] pool [12];
    void'($urandom(32'd20240611));
    do_reset();

    // R1: offsets inside block 0x48 and the first byte of block 0x49
    access(16'h1234, 1, 1'b0);
    access(16'h1200, 0, 1'b0);
    access(16'h123F, 0, 1'b0);
    access(16'h1238, 0, 1'b0);
    access(16'h1240, 2, 1'b0);

    // R4: fill the remaining six lines in order
    for (int b = 0; b < 6; b++) access(16'((10'h100 + b) << 6), b % 3, 1'b0);
    // R5: refresh the oldest line, then miss twice
    access(16'h1210, 0, 1'b0);
    access(16'h2000, 1, 1'b0);
    access(16'h1240, 1, 1'b0);  // R7 evicted block returns
    // R8: requests during a pending fill
    access(16'h3000, 3, 1'b1);

    // R9: reset in mid-run clears the touched-block record
    do_reset();
    access(16'h1240, 1, 1'b0);
    access(16'h1234, 0, 1'b0);

    // Random traffic over more blocks than lines
    for (int i = 0; i < 12; i++) pool[i] = 10'($urandom % 1024);
    for (int i = 0; i < 400; i++) begin
      logic [9:0] bsel;
      int lat;
      bit pk;
      bsel = pool[$urandom % 12];
      lat  = int'($urandom % 4);
      pk   = ($urandom % 8) == 0;
      if (pk && lat == 0) lat = 1;
      access({bsel, 6'($urandom % 64)}, lat, pk);
    end

    finish_run();
  end
endmodule